// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This unit sits in a decode or early-execute stage and decides whether a signed-compare conditional jump, or a jump-on-zero-count, is taken. Each request supplies up to two opcode bytes, the zero, sign and overflow flags, the count register, the address-size attribute and whether the core runs in 64-bit mode. One clock later the unit gives a registered, strobe-qualified result: taken or not, which displacement width the fetch logic must pull from the stream, and two separate flags for a form that is illegal in the current mode and for an opcode that is not one of its branches.

The short forms are one byte with an 8-bit displacement. The near forms are an escape byte followed by a second opcode byte, and their displacement is 16 or 32 bits. The count-zero jump always carries an 8-bit displacement and tests 16, 32 or 64 bits of the count, as the address-size attribute selects. No branch handled here writes any flag, so the unit has no flag outputs. Computing the target, fetching bytes and raising exceptions happen elsewhere.

Top module: `cbd_unit`

## Requirements
- R1: A request sampled with `req_valid` high yields `dec_valid` high exactly one clock later. A clock without a request yields `dec_valid` low one clock later.
- R2: Opcode 0x7D, or escape 0x0F followed by 0x8D ("greater or equal"), is taken exactly when the sign flag equals the overflow flag.
- R3: Opcode 0x7E, or 0x0F followed by 0x8E ("less or equal"), is taken when the zero flag is 1 or when the sign flag differs from the overflow flag.
- R4: Opcode 0x7F, or 0x0F followed by 0x8F ("greater"), is taken when the zero flag is 0 and the sign flag equals the overflow flag.
- R5: `disp_sel` encodes the displacement width as 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = none. Short forms and 0xE3 give 0. Near forms give 1 when `opsize16` is 1 and 2 otherwise.
- R6: Opcode 0xE3 in a legal mode is taken exactly when the tested bits of `count_val` are all zero: bits 15:0 for `addr_size` 0, bits 31:0 for 1, and bits 63:0 for 2.
- R7: For 0xE3, `bad_form` is 1 and `dec_taken` is 0 in three cases: `addr_size` 2 with `long_mode` 0, `addr_size` 0 with `long_mode` 1, and `addr_size` 3. Every other request gives `bad_form` 0.
- R8: Any other opcode, including 0x0F followed by a byte other than 0x8D to 0x8F, gives `not_branch` 1, `dec_taken` 0, `bad_form` 0 and `disp_sel` 3.
- R9: While reset is held, and after reset until the first request, `dec_valid`, `dec_taken`, `disp_sel`, `bad_form` and `not_branch` are all 0.
- R10: A clock without a request leaves `dec_taken`, `disp_sel`, `bad_form` and `not_branch` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| op_first | input | 8 | First opcode byte |
| op_second | input | 8 | Byte after the escape byte (used only after 0x0F) |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| count_val | input | CNT_W | Count register value |
| addr_size | input | 2 | Address size: 0 = 16, 1 = 32, 2 = 64, 3 = reserved |
| long_mode | input | 1 | Core is in 64-bit mode |
| opsize16 | input | 1 | Operand size is 16 bits |
| dec_valid | output | 1 | Result strobe, one clock after the request |
| dec_taken | output | 1 | Branch taken |
| disp_sel | output | 2 | Displacement width code |
| bad_form | output | 1 | Form illegal in the current mode |
| not_branch | output | 1 | Opcode is not handled by this unit |

## Verification
Every result is registered once, so the bench drives a request on a falling edge, lets one rising edge pass, and compares all five outputs on the next falling edge. A behavioural model in the bench works out the expected values for that request. On clocks with no request it keeps the previous decision fields and expects a low strobe. The outputs never settle at a clock edge, so the comparisons do not depend on the order in which processes run there.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
   typedef enum logic [1:0] {
      DW_8    = 2'd0,
      DW_16   = 2'd1,
      DW_32   = 2'd2,
      DW_NONE = 2'd3
   } disp_w_t;

   typedef enum logic [1:0] {
      AS_16  = 2'd0,
      AS_32  = 2'd1,
      AS_64  = 2'd2,
      AS_RSV = 2'd3
   } asize_t;

   typedef enum logic [2:0] {
      K_GE   = 3'd0,
      K_LE   = 3'd1,
      K_GT   = 3'd2,
      K_CNT  = 3'd3,
      K_NONE = 3'd4
   } br_kind_t;

   localparam logic [7:0] ESC_BYTE  = 8'h0F;
   localparam logic [7:0] SHORT_GE  = 8'h7D;
   localparam logic [7:0] SHORT_GT  = 8'h7F;
   localparam logic [7:0] NEAR_GE   = 8'h8D;
   localparam logic [7:0] NEAR_GT   = 8'h8F;
   localparam logic [7:0] CNT_JUMP  = 8'hE3;
   localparam int         NUM_CNT_W = 3;
   localparam int         MIN_CNT_W = 16;
   localparam int         MAX_CNT_W = MIN_CNT_W << (NUM_CNT_W - 1);
endpackage

// File: rtl/cbd_form_decode.sv
module cbd_form_decode
   import cbd_pkg::*;
(
   input  logic [7:0] op_first,
   input  logic [7:0] op_second,
   output br_kind_t   kind,
   output logic       is_near
);
   logic [7:0] cond_byte;
   logic       cond_range;

   always_comb begin
      is_near   = (op_first == ESC_BYTE);
      cond_byte = is_near ? op_second : op_first;
      if (is_near)
         cond_range = (op_second >= NEAR_GE) && (op_second <= NEAR_GT);
      else
         cond_range = (op_first >= SHORT_GE) && (op_first <= SHORT_GT);

      kind = K_NONE;
      if (cond_range) begin
         unique case (cond_byte[1:0])
            2'b01:   kind = K_GE;
            2'b10:   kind = K_LE;
            2'b11:   kind = K_GT;
            default: kind = K_NONE;
         endcase
      end else if (!is_near && op_first == CNT_JUMP) begin
         kind = K_CNT;
      end
   end
endmodule

// File: rtl/cbd_cond_eval.sv
module cbd_cond_eval
   import cbd_pkg::*;
(
   input  br_kind_t kind,
   input  logic     zf,
   input  logic     sf,
   input  logic     of_flag,
   output logic     hit
);
   logic sign_ok;

   always_comb begin
      sign_ok = (sf == of_flag);
      unique case (kind)
         K_GE:    hit = sign_ok;
         K_LE:    hit = zf | ~sign_ok;
         K_GT:    hit = ~zf & sign_ok;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/cbd_count_test.sv
module cbd_count_test
   import cbd_pkg::*;
#(
   parameter int CNT_W = 64
) (
   input  logic [CNT_W-1:0] count_val,
   input  asize_t           asize,
   input  logic             long_mode,
   output logic             is_zero,
   output logic             illegal
);
   logic [NUM_CNT_W-1:0] zero_at;

   generate
      if (CNT_W < MAX_CNT_W) begin : g_chk
         $error("cbd_count_test: CNT_W must cover the widest count test");
      end
      for (genvar i = 0; i < NUM_CNT_W; i++) begin : g_w
         localparam int W = MIN_CNT_W << i;
         assign zero_at[i] = (count_val[W-1:0] == '0);
      end
   endgenerate

   always_comb begin
      unique case (asize)
         AS_16:   begin is_zero = zero_at[0]; illegal = long_mode;  end
         AS_32:   begin is_zero = zero_at[1]; illegal = 1'b0;       end
         AS_64:   begin is_zero = zero_at[2]; illegal = ~long_mode; end
         default: begin is_zero = 1'b0;       illegal = 1'b1;       end
      endcase
   end
endmodule

// File: rtl/cbd_unit.sv
module cbd_unit
   import cbd_pkg::*;
#(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [7:0]       op_first,
   input  logic [7:0]       op_second,
   input  logic             flag_zf,
   input  logic             flag_sf,
   input  logic             flag_of,
   input  logic [CNT_W-1:0] count_val,
   input  logic [1:0]       addr_size,
   input  logic             long_mode,
   input  logic             opsize16,
   output logic             dec_valid,
   output logic             dec_taken,
   output logic [1:0]       disp_sel,
   output logic             bad_form,
   output logic             not_branch
);
   br_kind_t kind;
   logic     is_near, flag_hit, cnt_zero, cnt_bad;
   logic     nxt_taken, nxt_bad, nxt_nb;
   disp_w_t  nxt_disp;

   cbd_form_decode u_decode (
      .op_first (op_first),
      .op_second(op_second),
      .kind     (kind),
      .is_near  (is_near)
   );

   cbd_cond_eval u_cond (
      .kind   (kind),
      .zf     (flag_zf),
      .sf     (flag_sf),
      .of_flag(flag_of),
      .hit    (flag_hit)
   );

   cbd_count_test #(.CNT_W(CNT_W)) u_count (
      .count_val(count_val),
      .asize    (asize_t'(addr_size)),
      .long_mode(long_mode),
      .is_zero  (cnt_zero),
      .illegal  (cnt_bad)
   );

   always_comb begin
      nxt_nb    = (kind == K_NONE);
      nxt_bad   = (kind == K_CNT) && cnt_bad;
      nxt_taken = (kind == K_CNT) ? (cnt_zero && !cnt_bad) : flag_hit;
      if (nxt_nb)       nxt_disp = DW_NONE;
      else if (is_near) nxt_disp = opsize16 ? DW_16 : DW_32;
      else              nxt_disp = DW_8;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_taken  <= 1'b0;
         disp_sel   <= 2'd0;
         bad_form   <= 1'b0;
         not_branch <= 1'b0;
      end else begin
         dec_valid <= req_valid;
         if (req_valid) begin
            dec_taken  <= nxt_taken;
            disp_sel   <= nxt_disp;
            bad_form   <= nxt_bad;
            not_branch <= nxt_nb;
         end
      end
   end

   // R1: strobe follows the request by one clock
   a_r1_strobe_on: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   a_r1_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dec_valid);
   // R7: an illegal form is never taken
   a_r7_bad_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      bad_form |-> !dec_taken && !not_branch);
   // R8: a non-branch result is clean
   a_r8_nb_clean: assert property (@(posedge clk) disable iff (!rst_n)
      not_branch |-> !dec_taken && !bad_form && disp_sel == DW_NONE);
   // R10: decision fields hold without a request
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(dec_taken) && $stable(disp_sel)
                     && $stable(bad_form) && $stable(not_branch));
   // R5: near forms request a multi-byte displacement
   a_r5_near_wide: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && op_first == ESC_BYTE && op_second >= NEAR_GE
      && op_second <= NEAR_GT |=> disp_sel != DW_8 && disp_sel != DW_NONE);
endmodule

// File: tb/cbd_unit_tb.sv
module cbd_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  op_first = 8'h00, op_second = 8'h00;
   logic        flag_zf = 1'b0, flag_sf = 1'b0, flag_of = 1'b0;
   logic [63:0] count_val = 64'd0;
   logic [1:0]  addr_size = 2'd1;
   logic        long_mode = 1'b0, opsize16 = 1'b0;
   logic        dec_valid, dec_taken, bad_form, not_branch;
   logic [1:0]  disp_sel;

   int errors = 0, checks = 0;
   int e_taken = 0, e_disp = 0, e_bad = 0, e_nb = 0;

   always #2 clk = ~clk;

   cbd_unit #(.CNT_W(64)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .op_first(op_first), .op_second(op_second),
      .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of),
      .count_val(count_val), .addr_size(addr_size),
      .long_mode(long_mode), .opsize16(opsize16),
      .dec_valid(dec_valid), .dec_taken(dec_taken), .disp_sel(disp_sel),
      .bad_form(bad_form), .not_branch(not_branch)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // behavioural model; returns the requirement tag that governs "taken"
   task automatic model(input logic [7:0] a, input logic [7:0] b, input bit z, input bit s,
                        input bit o, input logic [63:0] c, input int as, input bit lm,
                        input bit o16, output string tag);
      int cc;
      bit near;
      near = (a == 8'h0F);
      cc = near ? int'(b) : int'(a);
      e_bad = 0; e_nb = 0; e_taken = 0;
      if ((near && (b == 8'h8D || b == 8'h8E || b == 8'h8F)) ||
          (!near && (a == 8'h7D || a == 8'h7E || a == 8'h7F))) begin
         e_disp = near ? (o16 ? 1 : 2) : 0;
         if (cc % 16 == 13) begin e_taken = (s == o);        tag = "R2"; end
         else if (cc % 16 == 14) begin e_taken = z || (s != o); tag = "R3"; end
         else begin e_taken = !z && (s == o);                tag = "R4"; end
      end else if (a == 8'hE3) begin
         e_disp = 0;
         if (as == 3 || (as == 2 && !lm) || (as == 0 && lm)) begin
            e_bad = 1; tag = "R7";
         end else begin
            tag = "R6";
            if (as == 0)      e_taken = (c[15:0] == 0);
            else if (as == 1) e_taken = (c[31:0] == 0);
            else              e_taken = (c == 0);
         end
      end else begin
         e_disp = 3; e_nb = 1; tag = "R8";
      end
   endtask

   task automatic run(input bit v, input logic [7:0] a, input logic [7:0] b, input bit z,
                      input bit s, input bit o, input logic [63:0] c, input int as,
                      input bit lm, input bit o16);
      string tag;
      req_valid = v; op_first = a; op_second = b;
      flag_zf = z; flag_sf = s; flag_of = o; count_val = c;
      addr_size = 2'(as); long_mode = lm; opsize16 = o16;
      if (v) model(a, b, z, s, o, c, as, lm, o16, tag);
      else tag = "R10";
      @(posedge clk);
      @(negedge clk);
      chk("R1", "dec_valid", int'(dec_valid), int'(v));
      chk(tag, "dec_taken", int'(dec_taken), e_taken);
      chk(v ? (e_nb != 0 ? "R8" : "R5") : "R10", "disp_sel", int'(disp_sel), e_disp);
      chk(v ? "R7" : "R10", "bad_form", int'(bad_form), e_bad);
      chk(v ? "R8" : "R10", "not_branch", int'(not_branch), e_nb);
   endtask

   task automatic check_zero(input string tag);
      chk(tag, "dec_valid", int'(dec_valid), 0);
      chk(tag, "dec_taken", int'(dec_taken), 0);
      chk(tag, "disp_sel", int'(disp_sel), 0);
      chk(tag, "bad_form", int'(bad_form), 0);
      chk(tag, "not_branch", int'(not_branch), 0);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      req_valid = 1'b1;
      repeat (3) @(negedge clk);
      check_zero("R9");
      rst_n = 1'b1;
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_zero("R9");
      // R2 greater-or-equal, short and near
      run(1, 8'h7D, 8'h00, 0, 1, 1, 64'd5, 1, 0, 0);
      run(1, 8'h7D, 8'h00, 1, 1, 0, 64'd5, 1, 0, 0);
      run(1, 8'h0F, 8'h8D, 0, 0, 0, 64'd5, 1, 0, 1);
      run(1, 8'h0F, 8'h8D, 0, 0, 1, 64'd5, 1, 0, 0);
      // R3 less-or-equal
      run(1, 8'h7E, 8'h00, 1, 0, 0, 64'd0, 1, 0, 0);
      run(1, 8'h7E, 8'h00, 0, 1, 0, 64'd0, 1, 0, 0);
      run(1, 8'h0F, 8'h8E, 0, 1, 1, 64'd0, 1, 1, 1);
      // R4 greater
      run(1, 8'h7F, 8'h00, 0, 1, 1, 64'd0, 1, 0, 0);
      run(1, 8'h7F, 8'h00, 1, 0, 0, 64'd0, 1, 0, 0);
      run(1, 8'h0F, 8'h8F, 0, 0, 1, 64'd0, 1, 0, 0);
      // R6 count width follows the address size
      run(1, 8'hE3, 8'h00, 0, 0, 0, 64'h0000_0000_0001_0000, 0, 0, 1);
      run(1, 8'hE3, 8'h00, 0, 0, 0, 64'h0000_0000_0001_0000, 1, 0, 1);
      run(1, 8'hE3, 8'h00, 0, 0, 0, 64'h0000_0001_0000_0000, 1, 1, 0);
      run(1, 8'hE3, 8'h00, 0, 0, 0, 64'h0000_0001_0000_0000, 2, 1, 0);
      run(1, 8'hE3, 8'h00, 0, 0, 0, 64'd0, 2, 1, 0);
      // R7 illegal count forms
      run(1, 8'hE3, 8'h00, 0, 0, 0, 64'd0, 2, 0, 0);
      run(1, 8'hE3, 8'h00, 0, 0, 0, 64'd0, 0, 1, 0);
      run(1, 8'hE3, 8'h00, 0, 0, 0, 64'd0, 3, 1, 0);
      // R10 hold with changing inputs and no request
      run(0, 8'h7E, 8'h00, 1, 0, 0, 64'd0, 1, 0, 0);
      run(0, 8'h44, 8'h00, 0, 0, 0, 64'd0, 1, 0, 0);
      // R8 unknown opcodes
      run(1, 8'h74, 8'h00, 1, 0, 0, 64'd0, 1, 0, 0);
      run(1, 8'h0F, 8'h8C, 1, 1, 0, 64'd0, 1, 0, 0);
      run(1, 8'h0F, 8'h7E, 1, 0, 0, 64'd0, 1, 0, 0);
      run(0, 8'hE3, 8'h00, 0, 0, 0, 64'd0, 1, 0, 0);
      // mixed patterns
      for (int i = 0; i < 400; i++) begin
         logic [7:0] a, b;
         logic [63:0] c;
         int pick;
         pick = int'($urandom_range(0, 9));
         case (pick)
            0, 1, 2: begin a = 8'h7D + 8'(pick); b = 8'($urandom); end
            3, 4, 5: begin a = 8'h0F; b = 8'h8D + 8'(pick - 3); end
            6, 7:    begin a = 8'hE3; b = 8'($urandom); end
            8:       begin a = 8'h0F; b = 8'($urandom); end
            default: begin a = 8'($urandom); b = 8'($urandom); end
         endcase
         case ($urandom_range(0, 3))
            0:       c = 64'd0;
            1:       c = 64'd1 << $urandom_range(0, 63);
            default: c = {$urandom, $urandom} & {48'd0, 16'($urandom)};
         endcase
         run(($urandom_range(0, 4) != 0), a, b, 1'($urandom), 1'($urandom), 1'($urandom),
             c, int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule